// File: doc/BRIEF.md
# Selectable-Strategy Branch Direction Predictor

This block gives a taken or not-taken guess for a conditional branch in the same cycle it is asked. A mode input chooses one of five strategies. Three are static: never taken, a guess based on the sign of the branch offset (a negative offset, meaning a backward branch, is taken), and a guess that follows a hint bit carried in the instruction. Two are dynamic and use tables indexed by low PC bits: a table of single bits that remembers the last outcome, and a table of two-bit saturating counters.

Resolved branches arrive on a separate update port and train both tables on every update, whatever mode is selected. A mode change therefore finds the dynamic tables already trained. Each table has 2^IDX_BITS entries, indexed by PC bits [IDX_BITS+1:2]. If a lookup and an update hit the same entry in one cycle, the lookup sees the value held before that clock edge.

Top module: `branch_dir_predictor`

## Requirements
- R1: With mode 0 (never taken), `pred_taken` is 0 for every query.
- R2: With mode 1 (offset sign), `pred_taken` equals the sign bit of `q_disp`: 1 for a negative offset and 0 for zero or a positive offset.
- R3: With mode 2 (hint), `pred_taken` equals `q_hint`.
- R4: With mode 3 (last outcome), `pred_taken` equals the last outcome written to the entry at PC bits [IDX_BITS+1:2].
- R5: With mode 4 (counter), an update with `upd_taken`=1 adds 1 to the entry's counter, up to a limit of 3. An update with `upd_taken`=0 subtracts 1, down to a limit of 0.
- R6: With mode 4, `pred_taken` is bit 1 of the indexed counter.
- R7: After reset, every last-outcome entry is 0 and every counter is 1, so both dynamic modes predict not taken.
- R8: Every update with `upd_valid`=1 trains both tables, whatever the mode. An update with `upd_valid`=0 changes nothing.
- R9: A lookup in the same cycle as an update to the same entry returns the old value. The new value is visible from the next cycle.
- R10: `pred_taken` is 0 whenever `q_valid` is 0. Mode values 5 to 7 act as mode 0.
- R11: For a loop branch taken three times and then not taken, visited repeatedly after warm-up, mode 3 mispredicts twice per visit and mode 4 mispredicts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Strategy select: 0 never, 1 offset sign, 2 hint, 3 last outcome, 4 counter |
| q_valid | input | 1 | Query valid |
| q_pc | input | 32 | PC of the branch being predicted |
| q_disp | input | 32 | Signed branch offset |
| q_hint | input | 1 | Hint bit from the instruction |
| pred_taken | output | 1 | Combinational prediction |
| upd_valid | input | 1 | Resolved-branch update valid |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the branch |

## Verification
A wrong table entry shows at `pred_taken` in the first cycle after the faulty update, but only while the matching dynamic mode is selected and only for a query to that entry. A wrong saturation limit or counter step stays hidden until a run of updates pushes the counter across its midpoint, so the bench drives runs longer than the counter range. Aliasing and a wrong index slice show as a prediction change on an entry that no update addressed.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
    typedef enum logic [2:0] {
        MODE_NEVER   = 3'd0,
        MODE_SIGN    = 3'd1,
        MODE_HINT    = 3'd2,
        MODE_LAST    = 3'd3,
        MODE_COUNTER = 3'd4
    } bdp_mode_e;

    localparam logic [1:0] CTR_MAX   = 2'd3;
    localparam logic [1:0] CTR_MIN   = 2'd0;
    localparam logic [1:0] CTR_RESET = 2'd1;
endpackage

// File: rtl/bdp_bit_table.sv
module bdp_bit_table #(
    parameter int IDX_BITS = 6,
    localparam int ENTRIES = 1 << IDX_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] rd_idx,
    output logic                rd_bit,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic                wr_bit
);
    typedef struct packed {
        logic [ENTRIES-1:0] bits;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.bits[wr_idx] = wr_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_bit = st_q.bits[rd_idx];

    AST_BIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.bits[$past(wr_idx)] == $past(wr_bit)); // R4
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.bits)); // R8
endmodule

// File: rtl/bdp_ctr_table.sv
module bdp_ctr_table
    import bdp_pkg::*;
#(
    parameter int IDX_BITS = 6,
    localparam int ENTRIES = 1 << IDX_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] rd_idx,
    output logic [1:0]          rd_ctr,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic                wr_up
);
    typedef struct packed {
        logic [ENTRIES-1:0][1:0] ctr;
    } state_t;

    state_t     st_d, st_q;
    logic [1:0] cur;

    always_comb begin
        st_d = st_q;
        cur  = st_q.ctr[wr_idx];
        if (wr_en) begin
            if (wr_up && cur != CTR_MAX)
                st_d.ctr[wr_idx] = cur + 2'd1;
            else if (!wr_up && cur != CTR_MIN)
                st_d.ctr[wr_idx] = cur - 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= {ENTRIES{CTR_RESET}};
        else        st_q <= st_d;
    end

    assign rd_ctr = st_q.ctr[rd_idx];

    AST_CTR_UP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && st_q.ctr[wr_idx] == CTR_MAX)
        |=> st_q.ctr[$past(wr_idx)] == CTR_MAX); // R5
    AST_CTR_DN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && st_q.ctr[wr_idx] == CTR_MIN)
        |=> st_q.ctr[$past(wr_idx)] == CTR_MIN); // R5
    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.ctr)); // R8
endmodule

// File: rtl/bdp_select.sv
module bdp_select
    import bdp_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       q_valid,
    input  logic       disp_sign,
    input  logic       hint,
    input  logic       last_bit,
    input  logic [1:0] ctr,
    output logic       taken
);
    logic raw;

    always_comb begin
        case (bdp_mode_e'(mode))
            MODE_SIGN:    raw = disp_sign;
            MODE_HINT:    raw = hint;
            MODE_LAST:    raw = last_bit;
            MODE_COUNTER: raw = ctr[1];
            default:      raw = 1'b0;
        endcase
        taken = q_valid & raw;
    end

    always_comb begin
        if (!q_valid) AST_IDLE_LOW: assert (!taken); // R10
    end
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor #(
    parameter int IDX_BITS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  mode,
    input  logic        q_valid,
    input  logic [31:0] q_pc,
    input  logic [31:0] q_disp,
    input  logic        q_hint,
    output logic        pred_taken,
    input  logic        upd_valid,
    input  logic [31:0] upd_pc,
    input  logic        upd_taken
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_BITS + 1;

    logic [IDX_BITS-1:0] rd_idx, wr_idx;
    logic                last_bit;
    logic [1:0]          ctr;

    assign rd_idx = q_pc[IDX_HI:IDX_LO];
    assign wr_idx = upd_pc[IDX_HI:IDX_LO];

    bdp_bit_table #(.IDX_BITS(IDX_BITS)) u_last (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_bit(last_bit),
        .wr_en(upd_valid), .wr_idx(wr_idx), .wr_bit(upd_taken)
    );

    bdp_ctr_table #(.IDX_BITS(IDX_BITS)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_ctr(ctr),
        .wr_en(upd_valid), .wr_idx(wr_idx), .wr_up(upd_taken)
    );

    bdp_select u_sel (
        .mode(mode), .q_valid(q_valid), .disp_sign(q_disp[31]),
        .hint(q_hint), .last_bit(last_bit), .ctr(ctr), .taken(pred_taken)
    );

    AST_NEVER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |-> !pred_taken); // R1
    AST_HINT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && q_valid) |-> pred_taken == q_hint); // R3
    AST_SIGN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && q_valid) |-> pred_taken == q_disp[31]); // R2
    AST_LAST_LEARN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && mode == 3'd3) ##1 (mode == 3'd3 && q_valid && q_pc == $past(upd_pc))
        |-> pred_taken == $past(upd_taken)); // R9
endmodule

// File: tb/branch_dir_predictor_test.sv
module branch_dir_predictor_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  mode = 0;
    logic        q_valid = 0;
    logic [31:0] q_pc = 0;
    logic [31:0] q_disp = 0;
    logic        q_hint = 0;
    logic        pred_taken;
    logic        upd_valid = 0;
    logic [31:0] upd_pc = 0;
    logic        upd_taken = 0;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    branch_dir_predictor uut (.*);

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic query(input logic [2:0] m, input logic [31:0] pc,
                         input logic [31:0] d, input logic h,
                         input logic exp, input string req);
        mode = m; q_valid = 1; q_pc = pc; q_disp = d; q_hint = h;
        #1 check(pred_taken, exp, req);
    endtask

    task automatic train(input logic [31:0] pc, input logic t);
        @(negedge clk);
        upd_valid = 1; upd_pc = pc; upd_taken = t;
        @(negedge clk);
        upd_valid = 0;
    endtask

    // static-mode vectors: mode, disp, hint, expected
    typedef struct packed {
        logic [2:0]  m;
        logic [31:0] d;
        logic        h;
        logic        e;
    } vec_t;
    localparam vec_t VECS [12] = '{
        '{3'd0, 32'hFFFF_FFF0, 1'b1, 1'b0},  // R1
        '{3'd0, 32'h0000_0010, 1'b0, 1'b0},  // R1
        '{3'd1, 32'hFFFF_FFF0, 1'b0, 1'b1},  // R2
        '{3'd1, 32'h0000_0010, 1'b1, 1'b0},  // R2
        '{3'd1, 32'h0000_0000, 1'b1, 1'b0},  // R2
        '{3'd1, 32'h8000_0000, 1'b0, 1'b1},  // R2
        '{3'd2, 32'hFFFF_FFF0, 1'b0, 1'b0},  // R3
        '{3'd2, 32'h0000_0010, 1'b1, 1'b1},  // R3
        '{3'd5, 32'hFFFF_FFF0, 1'b1, 1'b0},  // R10
        '{3'd7, 32'hFFFF_FFF0, 1'b1, 1'b0},  // R10
        '{3'd3, 32'h0000_0000, 1'b1, 1'b0},  // R7
        '{3'd4, 32'h0000_0000, 1'b1, 1'b0}   // R7
    };

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        foreach (VECS[i])
            query(VECS[i].m, 32'h100 + 32'(i) * 4, VECS[i].d, VECS[i].h, VECS[i].e,
                  (VECS[i].m == 0) ? "R1" : (VECS[i].m == 1) ? "R2" :
                  (VECS[i].m == 2) ? "R3" : (VECS[i].m >= 5) ? "R10" : "R7");

        // R10: no query
        mode = 3'd2; q_valid = 0; q_hint = 1;
        #1 check(pred_taken, 1'b0, "R10");

        // R4 / R8: training in mode 0 still trains tables
        mode = 3'd0;
        train(32'h40, 1'b1);
        query(3'd3, 32'h40, 0, 0, 1'b1, "R4 R8");
        query(3'd4, 32'h40, 0, 0, 1'b1, "R6 R8");
        train(32'h40, 1'b0);
        query(3'd3, 32'h40, 0, 0, 1'b0, "R4");
        query(3'd4, 32'h40, 0, 0, 1'b0, "R5");
        // R8: aliasing index check (0x40 index 16, 0x44 index 17 untouched)
        query(3'd4, 32'h44, 0, 0, 1'b0, "R8");

        // R5: saturate high then one down still taken
        for (int k = 0; k < 5; k++) train(32'h80, 1'b1);
        train(32'h80, 1'b0);
        query(3'd4, 32'h80, 0, 0, 1'b1, "R5");
        train(32'h80, 1'b0);
        query(3'd4, 32'h80, 0, 0, 1'b0, "R5");
        // saturate low then one up still not taken
        for (int k = 0; k < 5; k++) train(32'h80, 1'b0);
        train(32'h80, 1'b1);
        query(3'd4, 32'h80, 0, 0, 1'b0, "R5");
        train(32'h80, 1'b1);
        query(3'd4, 32'h80, 0, 0, 1'b1, "R6");

        // R8: upd_valid low changes nothing
        @(negedge clk);
        upd_valid = 0; upd_pc = 32'h80; upd_taken = 0;
        repeat (3) @(negedge clk);
        query(3'd4, 32'h80, 0, 0, 1'b1, "R8");

        // R9: same-cycle read sees old value
        @(negedge clk);
        upd_valid = 1; upd_pc = 32'hC0; upd_taken = 1;
        query(3'd3, 32'hC0, 0, 0, 1'b0, "R9");
        @(negedge clk);
        upd_valid = 0;
        query(3'd3, 32'hC0, 0, 0, 1'b1, "R9");

        // R11: loop pattern T T T N
        begin
            int miss1, miss2;
            logic p1, p2, o;
            for (int v = 0; v < 4; v++) begin
                miss1 = 0; miss2 = 0;
                for (int s = 0; s < 4; s++) begin
                    o = (s != 3);
                    mode = 3'd3; q_valid = 1; q_pc = 32'h200;
                    #1 p1 = pred_taken;
                    mode = 3'd4;
                    #1 p2 = pred_taken;
                    if (p1 != o) miss1++;
                    if (p2 != o) miss2++;
                    train(32'h200, o);
                end
                if (v >= 2) begin
                    checks++;
                    if (miss1 != 2) begin
                        fails++;
                        $display("FAIL R11: got %0d expected 2 (last-outcome)", miss1);
                    end
                    checks++;
                    if (miss2 != 1) begin
                        fails++;
                        $display("FAIL R11: got %0d expected 1 (counter)", miss2);
                    end
                end
            end
        end

        // R7: reset restores initial state
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        query(3'd3, 32'h80, 0, 0, 1'b0, "R7");
        query(3'd4, 32'h80, 0, 0, 1'b0, "R7");
        train(32'h80, 1'b1);
        query(3'd4, 32'h80, 0, 0, 1'b1, "R7");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule